// File: doc/BRIEF.md
# Windowed Challenge-Response Watchdog Sequencer

This block supervises a host processor with a challenge-response scheme. It publishes a 4-bit question, and in each watchdog cycle the host must write four answer bytes through a write strobe and an 8-bit data port. An internal timer splits every cycle into a first and a second response window. The lengths of the two windows, in clock cycles, come from two input ports. The block compares each byte with the byte expected for the current question and answer position. At the end of the cycle it decides whether the host passed.

A pass requires three correct bytes in the first window and a fourth correct byte in the second window. A pass moves the question on through a 4-bit shift-register generator and lowers a saturating failure counter. Any other outcome keeps the question, raises the counter and leaves the error flags set. The fourth write ends a cycle at once. Otherwise the cycle ends when the second window runs out. Between two cycles there is a single end cycle, in which writes are not accepted.

Top module: `qawd_seq`

## Requirements
- R1: While rst_n is low, and at the first clock after its release, question is 0, ans_idx is 3, fail_cnt is 0, ans_err, wd_err, in_win2 and cycle_end are 0.
- R2: A cycle begins with L1 clocks in window 1 (in_win2 = 0), followed by L2 clocks in window 2 (in_win2 = 1), where L1 = win1_len and L2 = win2_len and a length of 0 counts as 1. If fewer than four answers arrived, cycle_end is high for exactly one clock after window 2. The next cycle starts in window 1 on the clock after that.
- R3: The expected byte for question q and index i is B(q) XOR {4 copies of i[0], 4 copies of i[1]}, with the high nibble first. For q = 0..F, B(q) is 00,4F,16,59,8A,C5,9C,D3,2D,62,3B,74,A7,E8,B1,FE.
- R4: ans_idx is 3 at the start of every cycle and drops by one on each accepted write, so it selects the expected byte for the next answer.
- R5: The clock after a cycle's fourth accepted write, in either window, is the end cycle (cycle_end = 1).
- R6: A cycle passes only if exactly three writes landed in window 1 and exactly one in window 2, and all four bytes were correct. Four writes in window 1, no writes, or any other split is a fail.
- R7: On a pass, the question becomes {q[2:0], q[3]^q[2]}, and a result of 0 is replaced by 1. On a fail, and at all other times, the question holds.
- R8: fail_cnt drops by one after a pass and stays at 0 if already 0. It rises by one after a fail and stays at 15 if already 15. It changes at no other time.
- R9: A wrong byte sets ans_err and wd_err on the next clock. When a cycle ends, ans_err takes the value "a wrong byte arrived in this cycle" and wd_err takes the value "the cycle failed", so a pass clears both.
- R10: A write presented during the end cycle is ignored: the next cycle starts with ans_idx = 3, and that write does not count toward the next cycle's verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win1_len | input | TIMER_W | Window 1 length in clocks |
| win2_len | input | TIMER_W | Window 2 length in clocks |
| ans_we | input | 1 | Answer write strobe, one byte per clock |
| ans_data | input | 8 | Answer byte |
| question | output | 4 | Current question |
| ans_idx | output | 2 | Index of the next expected answer |
| fail_cnt | output | FAIL_W | Saturating failure counter |
| ans_err | output | 1 | Wrong byte seen |
| wd_err | output | 1 | Watchdog failure (any cause) |
| in_win2 | output | 1 | High during response window 2 |
| cycle_end | output | 1 | One-clock end-of-cycle strobe |

## Verification
Each wrong internal state shows at the ports within a short, fixed time. A wrong window counter moves the in_win2 edge, or the cycle_end pulse, away from the clock the bench predicts in that same cycle. A wrong tally of answers per window, or of byte correctness, gives the wrong verdict. That verdict is visible on the clock after cycle_end as a question that moved or held wrongly, a fail_cnt step in the wrong direction, or wrong flags. A bad answer index or a bad lookup entry makes a correct byte count as wrong, which raises ans_err on the very next clock.

// File: rtl/qawd_pkg.sv
// qawd_pkg: shared constants and pure functions of the Q&A watchdog.
// Assumes a 4-bit question and 2-bit answer index, fixed by the answer rule.
package qawd_pkg;

    localparam int QW    = 4;
    localparam int IDX_W = 2;
    localparam int BYTE_W = 8;
    localparam int TALLY_W = 3;

    // Window phase of the cycle timer.
    typedef enum logic {
        PH_WIN1 = 1'b0,
        PH_WIN2 = 1'b1
    } qawd_phase_e;

    // Base byte of a question: the answer expected at index 0.
    function automatic logic [BYTE_W-1:0] qawd_base(input logic [QW-1:0] q);
        logic [BYTE_W-1:0] b;
        case (q)
            4'h0: b = 8'h00;
            4'h1: b = 8'h4F;
            4'h2: b = 8'h16;
            4'h3: b = 8'h59;
            4'h4: b = 8'h8A;
            4'h5: b = 8'hC5;
            4'h6: b = 8'h9C;
            4'h7: b = 8'hD3;
            4'h8: b = 8'h2D;
            4'h9: b = 8'h62;
            4'hA: b = 8'h3B;
            4'hB: b = 8'h74;
            4'hC: b = 8'hA7;
            4'hD: b = 8'hE8;
            4'hE: b = 8'hB1;
            default: b = 8'hFE;
        endcase
        return b;
    endfunction

    // Expected byte: index bit 0 inverts the high nibble, bit 1 the low nibble.
    function automatic logic [BYTE_W-1:0] qawd_expected(input logic [QW-1:0] q,
                                                        input logic [IDX_W-1:0] idx);
        return qawd_base(q) ^ {{4{idx[0]}}, {4{idx[1]}}};
    endfunction

    // Next question: x^4+x^3+1 shift register, zero replaced by one.
    function automatic logic [QW-1:0] qawd_next_q(input logic [QW-1:0] q);
        logic [QW-1:0] n;
        n = {q[2:0], q[3] ^ q[2]};
        return (n == '0) ? 4'h1 : n;
    endfunction

endpackage

// File: rtl/qawd_cycle_timer.sv
// qawd_cycle_timer: splits a watchdog cycle into window 1 and window 2.
// Assumes restart is a one-clock pulse from the end cycle; a length of 0
// is treated as 1. Holds on the last window-2 clock until restarted.
module qawd_cycle_timer
    import qawd_pkg::*;
#(
    parameter int TIMER_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [TIMER_W-1:0] win1_len,
    input  logic [TIMER_W-1:0] win2_len,
    output logic               in_win2,
    output logic               win2_last
);

    qawd_phase_e        phase_q;
    logic [TIMER_W-1:0] cnt_q;
    logic [TIMER_W-1:0] win1_top;
    logic [TIMER_W-1:0] win2_top;

    // Last count value of each window.
    always_comb begin
        win1_top = (win1_len == '0) ? '0 : win1_len - 1'b1;
        win2_top = (win2_len == '0) ? '0 : win2_len - 1'b1;
    end

    // Window phase and position counter.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            phase_q <= PH_WIN1;
            cnt_q   <= '0;
        end else if (phase_q == PH_WIN1) begin
            if (cnt_q >= win1_top) begin
                phase_q <= PH_WIN2;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (cnt_q < win2_top) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Phase outputs.
    always_comb begin
        in_win2   = (phase_q == PH_WIN2);
        win2_last = (phase_q == PH_WIN2) && (cnt_q >= win2_top);
    end

endmodule

// File: rtl/qawd_answer_tally.sv
// qawd_answer_tally: checks answer bytes and counts them per window.
// Assumes accept is already masked during the end cycle; clear wins over
// accept. Produces the pass verdict from the tallies of the cycle.
module qawd_answer_tally
    import qawd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              accept,
    input  logic              in_win2,
    input  logic [BYTE_W-1:0] data,
    input  logic [QW-1:0]     question,
    output logic [IDX_W-1:0]  idx,
    output logic              last_answer,
    output logic              wrong_now,
    output logic              bad_seen,
    output logic              pass_ok
);

    logic [TALLY_W-1:0] total_q;
    logic [TALLY_W-1:0] win1_n_q;
    logic [TALLY_W-1:0] win2_n_q;
    logic               bad_q;
    logic [IDX_W-1:0]   idx_q;

    // Byte comparison against the expected answer for this position.
    always_comb begin
        wrong_now   = accept && (data != qawd_expected(question, idx_q));
        last_answer = accept && (total_q == TALLY_W'(3));
    end

    // Per-window counters, index and wrong-byte memory.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            total_q  <= '0;
            win1_n_q <= '0;
            win2_n_q <= '0;
            bad_q    <= 1'b0;
            idx_q    <= '1;
        end else if (accept) begin
            total_q <= total_q + 1'b1;
            idx_q   <= idx_q - 1'b1;
            if (in_win2) win2_n_q <= win2_n_q + 1'b1;
            else         win1_n_q <= win1_n_q + 1'b1;
            if (wrong_now) bad_q <= 1'b1;
        end
    end

    // Verdict of the cycle.
    always_comb begin
        idx      = idx_q;
        bad_seen = bad_q;
        pass_ok  = (win1_n_q == TALLY_W'(3)) && (win2_n_q == TALLY_W'(1)) && !bad_q;
    end

endmodule

// File: rtl/qawd_question_gen.sv
// qawd_question_gen: holds the question and steps it on a passing cycle.
// Assumes advance is a single-clock pulse.
module qawd_question_gen
    import qawd_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    output logic [QW-1:0] question
);

    logic [QW-1:0] q_q;

    // Question register.
    always_ff @(posedge clk) begin
        if (!rst_n)       q_q <= '0;
        else if (advance) q_q <= qawd_next_q(q_q);
    end

    assign question = q_q;

endmodule

// File: rtl/qawd_verdict.sv
// qawd_verdict: failure counter and error flags.
// Assumes cycle_end is a one-clock pulse carrying a valid pass decision.
module qawd_verdict #(
    parameter int FAIL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cycle_end,
    input  logic              pass,
    input  logic              bad_seen,
    input  logic              wrong_now,
    output logic [FAIL_W-1:0] fail_cnt,
    output logic              ans_err,
    output logic              wd_err
);

    localparam logic [FAIL_W-1:0] FAIL_MAX = '1;

    logic [FAIL_W-1:0] cnt_q;
    logic              ans_err_q;
    logic              wd_err_q;

    // Saturating failure counter, stepped once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cycle_end) begin
            if (pass) begin
                if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
            end else if (cnt_q != FAIL_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Error flags: set by wrong bytes, reloaded with the cycle verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ans_err_q <= 1'b0;
            wd_err_q  <= 1'b0;
        end else if (cycle_end) begin
            ans_err_q <= bad_seen;
            wd_err_q  <= !pass;
        end else if (wrong_now) begin
            ans_err_q <= 1'b1;
            wd_err_q  <= 1'b1;
        end
    end

    assign fail_cnt = cnt_q;
    assign ans_err  = ans_err_q;
    assign wd_err   = wd_err_q;

endmodule

// File: rtl/qawd_seq.sv
// qawd_seq: windowed multi-answer challenge-response watchdog.
// Assumes at most one answer write per clock. A cycle ends on its fourth
// accepted write or when window 2 expires; one end cycle follows, in which
// writes are dropped, the verdict is applied and the timer restarts.
module qawd_seq
    import qawd_pkg::*;
#(
    parameter int TIMER_W = 16,
    parameter int FAIL_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TIMER_W-1:0] win1_len,
    input  logic [TIMER_W-1:0] win2_len,
    input  logic               ans_we,
    input  logic [7:0]         ans_data,
    output logic [3:0]         question,
    output logic [1:0]         ans_idx,
    output logic [FAIL_W-1:0]  fail_cnt,
    output logic               ans_err,
    output logic               wd_err,
    output logic               in_win2,
    output logic               cycle_end
);

    logic end_q;
    logic accept;
    logic win2_last;
    logic last_answer;
    logic wrong_now;
    logic bad_seen;
    logic pass_ok;
    logic win2_now;

    // Writes count only outside the end cycle.
    assign accept = ans_we && !end_q;

    // End-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) end_q <= 1'b0;
        else        end_q <= !end_q && (last_answer || win2_last);
    end

    qawd_cycle_timer #(.TIMER_W(TIMER_W)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (end_q),
        .win1_len  (win1_len),
        .win2_len  (win2_len),
        .in_win2   (win2_now),
        .win2_last (win2_last)
    );

    qawd_answer_tally tally_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (end_q),
        .accept      (accept),
        .in_win2     (win2_now),
        .data        (ans_data),
        .question    (question),
        .idx         (ans_idx),
        .last_answer (last_answer),
        .wrong_now   (wrong_now),
        .bad_seen    (bad_seen),
        .pass_ok     (pass_ok)
    );

    qawd_question_gen qgen_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (end_q && pass_ok),
        .question (question)
    );

    qawd_verdict #(.FAIL_W(FAIL_W)) verdict_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cycle_end (end_q),
        .pass      (pass_ok),
        .bad_seen  (bad_seen),
        .wrong_now (wrong_now),
        .fail_cnt  (fail_cnt),
        .ans_err   (ans_err),
        .wd_err    (wd_err)
    );

    assign in_win2   = win2_now;
    assign cycle_end = end_q;

endmodule

// File: rtl/qawd_seq_chk.sv
// qawd_seq_chk: temporal properties of qawd_seq, observed at its ports.
module qawd_seq_chk
    import qawd_pkg::*;
#(
    parameter int FAIL_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ans_we,
    input logic [7:0]        ans_data,
    input logic [3:0]        question,
    input logic [1:0]        ans_idx,
    input logic [FAIL_W-1:0] fail_cnt,
    input logic              ans_err,
    input logic              wd_err,
    input logic              in_win2,
    input logic              cycle_end
);

    p_end_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_end |=> !cycle_end);

    p_restart_win1_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_end |=> !in_win2);

    p_idx_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_end |=> (ans_idx == 2'd3));

    p_q_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cycle_end |=> $stable(question));

    p_q_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_end |=> ($stable(question) || question != 4'h0));

    p_fail_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cycle_end |=> $stable(fail_cnt));

    p_fail_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_end |=> (fail_cnt == $past(fail_cnt) + 1'b1 ||
                       fail_cnt == $past(fail_cnt) - 1'b1 ||
                       $stable(fail_cnt)));

    p_wrong_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ans_we && !cycle_end && ans_data != qawd_expected(question, ans_idx))
        |=> (ans_err && wd_err));

    p_pass_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_end ##1 (question != $past(question)) |-> (!ans_err && !wd_err));

endmodule

bind qawd_seq qawd_seq_chk #(.FAIL_W(FAIL_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ans_we    (ans_we),
    .ans_data  (ans_data),
    .question  (question),
    .ans_idx   (ans_idx),
    .fail_cnt  (fail_cnt),
    .ans_err   (ans_err),
    .wd_err    (wd_err),
    .in_win2   (in_win2),
    .cycle_end (cycle_end)
);

// File: tb/qawd_seq_tb_top.sv
// Bench for qawd_seq: directed corners plus seeded random cycle plans.
module qawd_seq_tb_top;

    localparam int TW = 16;
    localparam int FW = 4;
    localparam int L1 = 6;
    localparam int L2 = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] win1_len = TW'(L1);
    logic [TW-1:0] win2_len = TW'(L2);
    logic          ans_we = 1'b0;
    logic [7:0]    ans_data = 8'h00;
    logic [3:0]    question;
    logic [1:0]    ans_idx;
    logic [FW-1:0] fail_cnt;
    logic          ans_err, wd_err, in_win2, cycle_end;

    int n_cmp = 0;
    int n_bad = 0;
    logic [3:0] mq = 4'h0;
    int         mf = 0;
    bit         done = 0;

    always #4 clk = ~clk;

    qawd_seq #(.TIMER_W(TW), .FAIL_W(FW)) dut_i (
        .clk(clk), .rst_n(rst_n), .win1_len(win1_len), .win2_len(win2_len),
        .ans_we(ans_we), .ans_data(ans_data), .question(question),
        .ans_idx(ans_idx), .fail_cnt(fail_cnt), .ans_err(ans_err),
        .wd_err(wd_err), .in_win2(in_win2), .cycle_end(cycle_end)
    );

    function automatic logic [7:0] base_of(input logic [3:0] q);
        logic [7:0] t [16] = '{8'h00, 8'h4F, 8'h16, 8'h59, 8'h8A, 8'hC5, 8'h9C, 8'hD3,
                               8'h2D, 8'h62, 8'h3B, 8'h74, 8'hA7, 8'hE8, 8'hB1, 8'hFE};
        return t[q];
    endfunction

    function automatic logic [7:0] want_byte(input logic [3:0] q, input int i);
        logic [1:0] ii = 2'(i);
        return base_of(q) ^ {{4{ii[0]}}, {4{ii[1]}}};
    endfunction

    function automatic logic [3:0] step_q(input logic [3:0] q);
        logic [3:0] n = {q[2:0], q[3] ^ q[2]};
        return (n == 4'h0) ? 4'h1 : n;
    endfunction

    task automatic chk(input string req, input int act, input int exp, input string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // One answer write at the current negedge; returns after the next negedge.
    task automatic put(input int k, input bit wrong, inout int t);
        chk("R4", ans_idx, 3 - k, "index before write");
        ans_we   = 1'b1;
        ans_data = want_byte(mq, 3 - k) ^ (wrong ? 8'h3C : 8'h00);
        @(negedge clk); t++;
        ans_we = 1'b0;
        if (wrong) begin
            chk("R9", ans_err, 1, "ans_err after wrong byte");
            chk("R9", wd_err, 1, "wd_err after wrong byte");
        end
    endtask

    // Runs one cycle from its first negedge; n1/n2 writes per window.
    task automatic do_cycle(input int n1, input int n2, input logic [3:0] bad, input bit stray);
        int  t = 0;
        int  k = 0;
        int  a1 = 0;
        int  a2 = 0;
        bit  anybad = 0;
        bit  pass;
        for (int i = 0; i < n1 && k < 4; i++) begin
            put(k, bad[k], t);
            anybad |= bad[k];
            k++; a1++;
        end
        if (k < 4) begin
            while (t < L1 - 1) begin @(negedge clk); t++; end
            chk("R2", in_win2, 0, "still window 1");
            @(negedge clk); t++;
            chk("R2", in_win2, 1, "window 2 entered");
            for (int i = 0; i < n2 && k < 4; i++) begin
                put(k, bad[k], t);
                anybad |= bad[k];
                k++; a2++;
            end
            if (k < 4) while (t < L1 + L2) begin @(negedge clk); t++; end
        end
        chk(k == 4 ? "R5" : "R2", cycle_end, 1, "end cycle strobe");
        pass = (a1 == 3) && (a2 == 1) && !anybad;
        if (stray) begin
            ans_we   = 1'b1;
            ans_data = want_byte(pass ? step_q(mq) : mq, 3);
        end
        if (pass) begin mq = step_q(mq); mf = (mf > 0) ? mf - 1 : 0; end
        else      begin mf = (mf < 15) ? mf + 1 : 15; end
        @(negedge clk);
        ans_we = 1'b0;
        chk("R7", question, mq, "question after cycle");
        chk("R8", fail_cnt, mf, "fail counter");
        chk("R9", ans_err, anybad, "ans_err verdict");
        chk("R6", wd_err, !pass, "wd_err verdict");
        chk("R10", ans_idx, 3, "index at cycle start");
        chk("R2", cycle_end, 0, "strobe one clock");
    endtask

    initial begin
        void'($urandom(32'h0051_A7ED));
        repeat (3) @(negedge clk);
        chk("R1", question, 0, "reset question");
        chk("R1", ans_idx, 3, "reset index");
        chk("R1", fail_cnt, 0, "reset counter");
        chk("R1", {ans_err, wd_err, in_win2, cycle_end}, 0, "reset flags");
        rst_n = 1'b1;
        chk("R1", ans_idx, 3, "index at release");
        do_cycle(3, 1, 4'b0000, 0);   // R6 pass
        do_cycle(0, 0, 4'b0000, 1);   // R6 no answers, R10 stray
        do_cycle(4, 0, 4'b0000, 0);   // R6 four in window 1
        do_cycle(2, 2, 4'b0000, 0);   // R6 wrong split
        do_cycle(3, 1, 4'b1000, 0);   // R3 wrong fourth
        do_cycle(3, 1, 4'b0001, 1);   // R9 wrong first
        do_cycle(3, 1, 4'b0000, 1);   // R10 stray after pass
        for (int i = 0; i < 17; i++) do_cycle(0, 0, 4'b0000, 0);  // R8 top
        for (int i = 0; i < 18; i++) do_cycle(3, 1, 4'b0000, 0);  // R7 walk, R8 floor
        for (int i = 0; i < 40; i++) begin
            if ($urandom % 2 == 0)
                do_cycle(3, 1, 4'b0000, 1'($urandom % 2));
            else
                do_cycle(int'($urandom % 5), int'($urandom % 3),
                         ($urandom % 3 == 0) ? 4'($urandom) : 4'b0000, 1'($urandom % 2));
        end
        if (!done) begin
            done = 1;
            report();
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            report();
            $finish;
        end
    end

endmodule